// File: doc/BRIEF.md
# Two-Thread Partitioned Decoupling Queue

This block sits between two pipeline stages that are shared by two hardware threads. The upstream stage pushes at most one entry per clock, tagged with the thread that owns it. The downstream stage removes at most one entry per clock, and the block chooses which thread that entry comes from. In the normal shared mode the storage is cut into two fixed halves, one per thread, with no overlap. A thread that backs up can therefore fill only its own half and never starves the other thread of space.

The read-side allocator alternates between the threads on every clock while both have work. It skips a thread that is stalled, halted or at its downstream credit cap, and keeps serving the other thread back to back. Downstream resource use enters as one held-resource count per thread. A single-thread mode hands the whole storage to one chosen thread. The change between modes waits until the queue has fully drained.

Top module: `dual_thread_split_queue`

## Requirements
- R1: In shared mode (`solo_act`=0) each thread accepts at most DEPTH/2 entries. `push_ready[t]` is low while thread t holds DEPTH/2 entries, and this has no effect on the other thread's `push_ready` bit.
- R2: Each popped entry carries in `pop_tid` the thread ID it was pushed with. Each thread's entries leave in the order that thread pushed them.
- R3: When both threads are eligible in a cycle, the served thread differs from the one served in the previous serving cycle, so two eligible threads are served alternately on every clock.
- R4: A thread whose `stall` bit is 1 is never served. The other thread, if it has entries, is served on consecutive cycles.
- R5: A thread whose `halt` bit is 1 is never served. The other thread, if it has entries, is served on consecutive cycles.
- R6: A thread whose held-resource input is at or above CRED_CAP is treated as stalled. At CRED_CAP-1 it is eligible.
- R7: After any serving cycle, including one where only one thread was eligible, the next cycle with both threads eligible serves the thread that was not served last. After reset, thread 0 is preferred.
- R8: In single-thread mode (`solo_act`=1) the owner thread accepts up to DEPTH entries, and the other thread's `push_ready` bit is 0.
- R9: A mode request (`solo_req`, `solo_tid`) that differs from the current mode holds both `push_ready` bits at 0. The mode changes on the first clock edge at which both partitions are empty. `solo_act` never changes while any entry is stored.
- R10: After reset the queue is empty, `pop_valid` is 0, both `push_ready` bits are 1, the mode is shared and thread 0 is preferred.
- R11: A push accepted at a clock edge can be popped in the cycle that follows that edge, not earlier. `pop_valid`, `pop_tid` and `pop_data` present the chosen entry in the same cycle, and the entry is removed at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Upstream offers an entry |
| push_tid | input | 1 | Thread owning the offered entry |
| push_data | input | DATA_W | Entry payload |
| push_ready | output | 2 | Per-thread acceptance; bit t refers to thread t |
| stall | input | 2 | Per-thread downstream stall |
| halt | input | 2 | Per-thread halted state |
| held0 | input | CRED_W | Downstream resources held by thread 0 |
| held1 | input | CRED_W | Downstream resources held by thread 1 |
| solo_req | input | 1 | Request single-thread mode |
| solo_tid | input | 1 | Thread that owns the storage in single-thread mode |
| solo_act | output | 1 | Current mode, 1 = single-thread |
| pop_valid | output | 1 | An entry is being handed downstream this cycle |
| pop_tid | output | 1 | Owner tag of the handed entry |
| pop_data | output | DATA_W | Payload of the handed entry |

## Verification
A corrupted pointer or counter shows up as wrong, repeated or missing data in the pop stream. The scoreboard catches it on the first pop of the affected thread, or as `push_ready` refusing or granting one entry too early when a partition fills. A wrong preference bit shows up as two same-thread pops in a row while both threads are eligible, which is visible within a single cycle. A mode register that switches early appears as pushes accepted while a request is pending, or as entries landing in the other thread's half and coming out under the wrong tag.

// File: rtl/dual_thread_split_queue.sv
module dual_thread_split_queue #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 8,
  parameter int CRED_W   = 4,
  parameter int CRED_CAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic              push_tid,
  input  logic [DATA_W-1:0] push_data,
  output logic [1:0]        push_ready,
  input  logic [1:0]        stall,
  input  logic [1:0]        halt,
  input  logic [CRED_W-1:0] held0,
  input  logic [CRED_W-1:0] held1,
  input  logic              solo_req,
  input  logic              solo_tid,
  output logic              solo_act,
  output logic              pop_valid,
  output logic              pop_tid,
  output logic [DATA_W-1:0] pop_data
);
  localparam int HALF = DEPTH / 2;
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);

  logic [DATA_W:0] mem [DEPTH];
  logic solo_q, owner_q, pref_q;
  logic [1:0][AW-1:0] rp, wp;
  logic [1:0][CW-1:0] cnt, lim;
  logic [1:0][CRED_W-1:0] held;
  logic [1:0] elig, fire, take;
  logic pending, switch_now, pick;
  logic [AW-1:0] base1, rd_addr, wr_addr;
  logic [DATA_W:0] rd_word;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [CW-1:0] l);
    return (CW'(p) + CW'(1) == l) ? '0 : p + AW'(1);
  endfunction

  assign held       = {held1, held0};
  assign solo_act   = solo_q;
  assign pending    = (solo_req != solo_q) || (solo_req && solo_tid != owner_q);
  assign switch_now = pending && cnt[0] == '0 && cnt[1] == '0;
  assign base1      = solo_q ? '0 : AW'(HALF);

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      lim[t] = solo_q ? ((owner_q == 1'(t)) ? CW'(DEPTH) : '0) : CW'(HALF);
      push_ready[t] = !pending && cnt[t] < lim[t];
      elig[t] = cnt[t] != '0 && !stall[t] && !halt[t] && held[t] < CRED_W'(CRED_CAP);
      fire[t] = push_valid && push_tid == 1'(t) && push_ready[t];
    end
  end

  assign pick      = (elig == 2'b11) ? pref_q : elig[1];
  assign pop_valid = |elig;
  assign take      = {pop_valid && pick, pop_valid && !pick};
  assign rd_addr   = (pick ? base1 : '0) + rp[pick];
  assign wr_addr   = (push_tid ? base1 : '0) + wp[push_tid];
  assign rd_word   = mem[rd_addr];
  assign pop_tid   = rd_word[DATA_W];
  assign pop_data  = rd_word[DATA_W-1:0];

  always_ff @(posedge clk)
    if (|fire) mem[wr_addr] <= {push_tid, push_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      solo_q  <= 1'b0;
      owner_q <= 1'b0;
      pref_q  <= 1'b0;
      rp      <= '0;
      wp      <= '0;
      cnt     <= '0;
    end else begin
      if (pop_valid) pref_q <= ~pick;
      if (switch_now) begin
        solo_q  <= solo_req;
        owner_q <= solo_tid;
        rp      <= '0;
        wp      <= '0;
      end else begin
        for (int t = 0; t < 2; t++) begin
          if (fire[t]) wp[t] <= bump(wp[t], lim[t]);
          if (take[t]) rp[t] <= bump(rp[t], lim[t]);
        end
      end
      for (int t = 0; t < 2; t++)
        cnt[t] <= cnt[t] + CW'(fire[t]) - CW'(take[t]);
    end
  end
endmodule

module split_queue_chk #(
  parameter int DEPTH    = 8,
  parameter int CW       = 4,
  parameter int CRED_W   = 4,
  parameter int CRED_CAP = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0][CW-1:0]     cnt,
  input logic [1:0]             elig,
  input logic [1:0][CRED_W-1:0] held,
  input logic [1:0]             stall,
  input logic [1:0]             halt,
  input logic                   solo_act,
  input logic                   pop_valid,
  input logic                   pop_tid
);
  a_r1_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !solo_act |-> (cnt[0] <= CW'(DEPTH/2) && cnt[1] <= CW'(DEPTH/2)));

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == 2'b11 && $past(pop_valid)) |-> pop_tid != $past(pop_tid));

  // R5 and R6 share this check with R4
  a_r4_blocked_skip: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> (!stall[pop_tid] && !halt[pop_tid] && held[pop_tid] < CRED_W'(CRED_CAP)));

  a_r8_solo_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    solo_act |-> (cnt[0] == '0 || cnt[1] == '0));

  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] != '0 || cnt[1] != '0) |=> $stable(solo_act));
endmodule

bind dual_thread_split_queue split_queue_chk #(
  .DEPTH(DEPTH), .CW(CW), .CRED_W(CRED_W), .CRED_CAP(CRED_CAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .elig(elig), .held(held),
  .stall(stall), .halt(halt), .solo_act(solo_act),
  .pop_valid(pop_valid), .pop_tid(pop_tid)
);

// File: tb/dual_thread_split_queue_tb.sv
`timescale 1ns/1ps
module dual_thread_split_queue_tb;
  localparam int CAP = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, push_tid = 1'b0;
  logic [7:0] push_data = '0;
  logic [1:0] push_ready, stall = '0, halt = '0;
  logic [3:0] held0 = '0, held1 = '0;
  logic solo_req = 1'b0, solo_tid = 1'b0, solo_act;
  logic pop_valid, pop_tid;
  logic [7:0] pop_data;

  int checks = 0, errors = 0;
  logic [7:0] exp0[$], exp1[$];
  int seen[$], want[$];

  always #2 clk = ~clk;

  dual_thread_split_queue #(.DATA_W(8), .DEPTH(8), .CRED_W(4), .CRED_CAP(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_tid(push_tid),
    .push_data(push_data), .push_ready(push_ready), .stall(stall), .halt(halt),
    .held0(held0), .held1(held1), .solo_req(solo_req), .solo_tid(solo_tid),
    .solo_act(solo_act), .pop_valid(pop_valid), .pop_tid(pop_tid), .pop_data(pop_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pop_valid) begin
      logic [7:0] e;
      seen.push_back(int'(pop_tid));
      if ((pop_tid ? exp1.size() : exp0.size()) == 0)
        chk(1'b0, "R2 pop with nothing expected", int'(pop_data), -1);
      else begin
        e = pop_tid ? exp1.pop_front() : exp0.pop_front();
        chk(pop_data == e, "R2 pop data order", int'(pop_data), int'(e));
      end
    end
  end

  task automatic push(input bit tid, input logic [7:0] d, output bit ok);
    push_valid = 1'b1; push_tid = tid; push_data = d;
    @(negedge clk);
    ok = push_ready[tid];
    if (ok) begin
      if (tid) exp1.push_back(d); else exp0.push_back(d);
    end
    @(posedge clk); #1;
    push_valid = 1'b0;
  endtask

  task automatic fill(input bit tid, input int n, input logic [7:0] b);
    bit ok;
    for (int i = 0; i < n; i++) begin
      push(tid, b + 8'(i), ok);
      chk(ok, "R1 fill accepted", int'(ok), 1);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_seq(input string req);
    chk(seen.size() == want.size(), req, seen.size(), want.size());
    for (int i = 0; i < want.size() && i < seen.size(); i++)
      chk(seen[i] == want[i], req, seen[i], want[i]);
  endtask

  initial begin
    bit ok;
    int acc;
    run(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pop_valid == 1'b0, "R10 pop_valid after reset", int'(pop_valid), 0);
    chk(push_ready == 2'b11, "R10 push_ready after reset", int'(push_ready), 3);
    chk(solo_act == 1'b0, "R10 shared mode after reset", int'(solo_act), 0);
    @(posedge clk); #1;

    // R11: push visible only after the accepting edge
    push_valid = 1'b1; push_tid = 1'b0; push_data = 8'h5A;
    @(negedge clk);
    chk(pop_valid == 1'b0, "R11 no pop in push cycle", int'(pop_valid), 0);
    exp0.push_back(8'h5A);
    @(posedge clk); #1; push_valid = 1'b0;
    @(negedge clk);
    chk(pop_valid && pop_tid == 1'b0, "R11 pop next cycle", int'(pop_valid), 1);
    run(3);

    // R1 partition bound, R3 alternation
    halt = 2'b11;
    fill(1'b0, 4, 8'h10);
    push(1'b0, 8'hEE, ok);
    chk(!ok, "R1 fifth push to thread 0 refused", int'(ok), 0);
    @(negedge clk);
    chk(push_ready[1] == 1'b1, "R1 thread 1 unaffected", int'(push_ready[1]), 1);
    @(posedge clk); #1;
    fill(1'b1, 4, 8'h80);
    push(1'b1, 8'hEF, ok);
    chk(!ok, "R1 fifth push to thread 1 refused", int'(ok), 0);
    seen.delete(); halt = 2'b00; run(12);
    want = '{1, 0, 1, 0, 1, 0, 1, 0};
    chk_seq("R3 alternation");

    // R4 stall
    halt = 2'b11;
    fill(1'b0, 3, 8'h20); fill(1'b1, 3, 8'h90);
    stall = 2'b01; seen.delete(); halt = 2'b00; run(6);
    stall = 2'b00; run(6);
    want = '{1, 1, 1, 0, 0, 0};
    chk_seq("R4 stalled thread skipped");

    // R5 halt and R7 resume
    halt = 2'b11;
    fill(1'b0, 3, 8'h30); fill(1'b1, 2, 8'hA0);
    seen.delete(); halt = 2'b10; run(2);
    halt = 2'b00; run(6);
    want = '{0, 0, 1, 0, 1};
    chk_seq("R5 R7 halt then resume");

    // R6 credit cap
    halt = 2'b11;
    fill(1'b0, 2, 8'h40); fill(1'b1, 2, 8'hB0);
    held1 = 4'(CAP); seen.delete(); halt = 2'b00; run(5);
    held1 = 4'(CAP - 1); run(5);
    want = '{0, 0, 1, 1};
    chk_seq("R6 credit cap");
    held1 = '0;

    // R9 pending mode change, R8 single-thread mode
    halt = 2'b11;
    fill(1'b0, 1, 8'h55);
    solo_req = 1'b1; solo_tid = 1'b1;
    @(negedge clk);
    chk(push_ready == 2'b00, "R9 pushes refused while pending", int'(push_ready), 0);
    chk(solo_act == 1'b0, "R9 no switch while not empty", int'(solo_act), 0);
    @(posedge clk); #1;
    halt = 2'b00; run(4);
    @(negedge clk);
    chk(solo_act == 1'b1, "R9 switch after drain", int'(solo_act), 1);
    chk(push_ready == 2'b10, "R8 only owner ready", int'(push_ready), 2);
    @(posedge clk); #1;
    halt = 2'b11;
    acc = 0;
    for (int i = 0; i < 8; i++) begin
      push(1'b1, 8'hC0 + 8'(i), ok);
      if (ok) acc++;
    end
    chk(acc == 8, "R8 owner takes full depth", acc, 8);
    push(1'b1, 8'hFE, ok);
    chk(!ok, "R8 owner refused beyond depth", int'(ok), 0);
    push(1'b0, 8'hFD, ok);
    chk(!ok, "R8 other thread refused", int'(ok), 0);
    seen.delete(); halt = 2'b00; run(12);
    want = '{1, 1, 1, 1, 1, 1, 1, 1};
    chk_seq("R8 single-thread drain");
    solo_req = 1'b0; run(3);
    @(negedge clk);
    chk(solo_act == 1'b0, "R9 back to shared", int'(solo_act), 0);
    chk(push_ready == 2'b11, "R9 both ready in shared", int'(push_ready), 3);

    chk(exp0.size() == 0 && exp1.size() == 0, "R2 all entries delivered",
        exp0.size() + exp1.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule